// File: doc/BRIEF.md
# PIPE PHY Control Status Sequencer

This block is the control plane of a single-lane PIPE-style physical layer. It sits behind the control pins that face the MAC. It produces the status strobe and the receive status code that the MAC watches, and it raises a beacon request towards the serializer. Three jobs share the one status line. The line is held high through reset and while the PLL settles. It is pulsed for one cycle to complete a far-end receiver detection. It is gated by the power-down code.

The MAC holds reset low to start the block, and then waits for the status line to fall before it begins normal operation. To probe for a link partner, the MAC puts the block in P1, raises the detect request, and waits for the status pulse. It reads the result from the receive status field in the same cycle and then drops the request. In P2, the MAC lowers transmit-idle to keep beacons going out. A falling receive-idle in P2 is reported as a beacon from the partner.

The analog parts are modelled as plain input flags: PLL lock, detection done, and far end present. The PLL settle time is a parameter counted in clock cycles.

Top module: `pipe_ctl_seq`

## Requirements
- R1: While `rst_n` is low, `phy_status` is 1 with no clock needed, `rx_status` is 000, and `beacon_en` and `beacon_seen` are 0, whatever the other inputs are.
- R2: After reset is released, `phy_status` stays 1 until `pll_locked` has been sampled high on SETTLE_CYCLES rising edges. The count pauses while `pll_locked` is low. `phy_status` goes to 0 after the edge that completes the count.
- R3: A detect request (`det_req`=1) starts a detection only when the block is ready and `pwr_state` is P1 (2'b10). The codes are P0=00, P0s=01, P1=10 and P2=11. In any other state, `det_req` and `det_done` leave `phy_status` at 0 and `rx_status` at 000.
- R4: During a detection, a `det_done` sampled high on a rising edge gives a `phy_status` pulse of exactly one cycle after that edge. The result is on `rx_status` in the same cycle.
- R5: The result code is 3'b011 when `far_present` is 1 and 3'b000 when it is 0.
- R6: The result stays on `rx_status` while `det_req` is held. It returns to 000 one edge after `det_req` is sampled low.
- R7: `beacon_en` is 1, combinationally, exactly when the block is ready, `pwr_state` is P2 and `tx_idle` is 0.
- R8: In P2, a high-to-low change of `rx_idle` between two rising edges gives a one-cycle `beacon_seen` pulse after the second edge. In other power states the change gives no pulse.
- R9: If `det_req` is withdrawn before `det_done`, the detection is abandoned. A later `det_done` with no request gives no `phy_status` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_state | input | 2 | Power-down code: P0=00, P0s=01, P1=10, P2=11 |
| det_req | input | 1 | Receiver detection request from the MAC |
| tx_idle | input | 1 | Transmit electrical idle request |
| rx_idle | input | 1 | Receive electrical idle seen on the line |
| pll_locked | input | 1 | PLL lock flag |
| det_done | input | 1 | Analog detection circuit finished |
| far_present | input | 1 | Analog detection found a far-end receiver |
| phy_status | output | 1 | PHY status strobe / not-ready level |
| rx_status | output | 3 | Receive status code |
| beacon_en | output | 1 | Request to transmit beacons repeatedly |
| beacon_seen | output | 1 | One-cycle pulse on a beacon from the partner |

## Verification
`phy_status` during reset and `beacon_en` are combinational, so they are due in the same cycle as the input change. The detection pulse, the result code, the return of `rx_status` to 000 and `beacon_seen` each come one rising edge after the input that causes them. The settle release comes on the edge that completes the SETTLE_CYCLES lock count. The driver changes inputs 2 ns after a rising edge and queues the outputs expected after the next edge. The monitor reads outputs 1 ns after each edge, so every expected value is compared in exactly the cycle it is due. The reset state is checked directly with the clock still running and no edge dependency.

// File: rtl/pipe_ctl_seq.sv
module pipe_ctl_seq #(
  parameter int SETTLE_CYCLES = 4175
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state,
  input  logic       det_req,
  input  logic       tx_idle,
  input  logic       rx_idle,
  input  logic       pll_locked,
  input  logic       det_done,
  input  logic       far_present,
  output logic       phy_status,
  output logic [2:0] rx_status,
  output logic       beacon_en,
  output logic       beacon_seen
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [1:0] PD_P1 = 2'b10;
  localparam logic [1:0] PD_P2 = 2'b11;
  localparam logic [2:0] CODE_NONE = 3'b000;
  localparam logic [2:0] CODE_FOUND = 3'b011;

  typedef enum logic [1:0] {DS_IDLE, DS_WAIT, DS_HOLD} det_st_t;

  logic [CW-1:0] settle_cnt;
  logic          settling;
  det_st_t       det_st;
  logic          det_pulse;
  logic [2:0]    rx_code;
  logic          rx_idle_q;

  wire ready = ~settling;
  wire in_p1 = (pwr_state == PD_P1);
  wire in_p2 = (pwr_state == PD_P2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      settling   <= 1'b1;
    end else if (settling && pll_locked) begin
      if (settle_cnt == CW'(SETTLE_CYCLES - 1)) settling <= 1'b0;
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_st    <= DS_IDLE;
      det_pulse <= 1'b0;
      rx_code   <= CODE_NONE;
    end else begin
      det_pulse <= 1'b0;
      case (det_st)
        DS_IDLE: if (ready && in_p1 && det_req) det_st <= DS_WAIT;
        DS_WAIT: begin
          if (!det_req || !in_p1) det_st <= DS_IDLE;
          else if (det_done) begin
            det_pulse <= 1'b1;
            rx_code   <= far_present ? CODE_FOUND : CODE_NONE;
            det_st    <= DS_HOLD;
          end
        end
        DS_HOLD: if (!det_req) begin
          det_st  <= DS_IDLE;
          rx_code <= CODE_NONE;
        end
        default: det_st <= DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idle_q   <= 1'b1;
      beacon_seen <= 1'b0;
    end else begin
      rx_idle_q   <= rx_idle;
      beacon_seen <= in_p2 && rx_idle_q && !rx_idle;
    end
  end

  assign phy_status = !rst_n || settling || det_pulse;
  assign rx_status  = rx_code;
  assign beacon_en  = rst_n && ready && in_p2 && !tx_idle;

  p_reset_high_r1: assert property (@(posedge clk) !rst_n |-> phy_status);

  p_settle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && !pll_locked) |=> settling);

  p_ignore_non_p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (det_st == DS_IDLE && !in_p1) |=> !det_pulse);

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |=> !det_pulse);

  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status == CODE_NONE) || (rx_status == CODE_FOUND));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_st == DS_HOLD && !det_req) |=> (rx_status == CODE_NONE));

  p_beacon_p2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_en |-> (pwr_state == PD_P2));

  p_seen_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_seen |=> !beacon_seen);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_st == DS_WAIT && !det_req) |=> (det_st == DS_IDLE && !det_pulse));

endmodule

// File: tb/test_pipe_ctl_seq.sv
module test_pipe_ctl_seq;
  localparam int SETTLE = 8;
  localparam logic [1:0] P0 = 2'b00, P1 = 2'b10, P2 = 2'b11;

  logic clk = 0;
  logic rst_n, det_req, tx_idle, rx_idle, pll_locked, det_done, far_present;
  logic [1:0] pwr_state;
  logic phy_status, beacon_en, beacon_seen;
  logic [2:0] rx_status;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  typedef struct {
    logic ps;
    logic [2:0] rs;
    logic be;
    logic bs;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pipe_ctl_seq #(.SETTLE_CYCLES(SETTLE)) i_pipe_ctl_seq (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .det_req(det_req),
    .tx_idle(tx_idle), .rx_idle(rx_idle), .pll_locked(pll_locked),
    .det_done(det_done), .far_present(far_present), .phy_status(phy_status),
    .rx_status(rx_status), .beacon_en(beacon_en), .beacon_seen(beacon_seen)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (phy_status !== e.ps || rx_status !== e.rs || beacon_en !== e.be || beacon_seen !== e.bs) begin
      errors++;
      $display("FAIL %s act ps=%b rs=%b be=%b bs=%b exp ps=%b rs=%b be=%b bs=%b",
               e.tag, phy_status, rx_status, beacon_en, beacon_seen, e.ps, e.rs, e.be, e.bs);
    end
  endtask

  task automatic cyc(input logic r, input logic pll, input logic [1:0] pd, input logic req,
                     input logic txi, input logic rxi, input logic far, input logic dn,
                     input logic ps, input logic [2:0] rs, input logic be, input logic bs,
                     input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    rst_n = r; pll_locked = pll; pwr_state = pd; det_req = req;
    tx_idle = txi; rx_idle = rxi; far_present = far; det_done = dn;
    e.ps = ps; e.rs = rs; e.be = be; e.bs = bs; e.tag = tag;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 0; pll_locked = 0; pwr_state = P2; det_req = 0; tx_idle = 0;
    rx_idle = 1; far_present = 0; det_done = 0;
    #3;
    e.ps = 1; e.rs = 0; e.be = 0; e.bs = 0; e.tag = "R1 reset at time 3";
    compare(e);
    repeat (3) @(posedge clk);
    #3;
    e.tag = "R1 reset held in P2";
    compare(e);

    // R2: three unlocked cycles, then the lock count runs
    for (int i = 0; i < 3; i++) cyc(1,0,P1,0,1,1,0,0, 1,3'b000,0,0, "R2 unlocked");
    for (int i = 0; i < SETTLE-1; i++) cyc(1,1,P1,0,1,1,0,0, 1,3'b000,0,0, "R2 settling");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R2 ready");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R2 ready idle");

    // Detection with the far end present
    cyc(1,1,P1,1,1,1,0,0, 0,3'b000,0,0, "R3 start in P1");
    cyc(1,1,P1,1,1,1,1,1, 1,3'b011,0,0, "R4 pulse present");
    cyc(1,1,P1,1,1,1,1,0, 0,3'b011,0,0, "R6 hold result");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R6 release");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R6 idle");

    // Detection with no far end
    cyc(1,1,P1,1,1,1,0,0, 0,3'b000,0,0, "R3 start absent");
    cyc(1,1,P1,1,1,1,0,1, 1,3'b000,0,0, "R5 pulse absent");
    cyc(1,1,P1,1,1,1,0,0, 0,3'b000,0,0, "R4 single pulse");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R6 release absent");

    // Requests outside P1 are ignored
    for (int i = 0; i < 3; i++) cyc(1,1,P0,1,1,1,1,1, 0,3'b000,0,0, "R3 ignored in P0");
    for (int i = 0; i < 3; i++) cyc(1,1,P2,1,1,1,1,1, 0,3'b000,0,0, "R3 ignored in P2");
    cyc(1,1,P2,0,1,1,0,0, 0,3'b000,0,0, "R3 drop");

    // Abandoned request
    cyc(1,1,P1,1,1,1,0,0, 0,3'b000,0,0, "R9 start");
    cyc(1,1,P1,0,1,1,0,0, 0,3'b000,0,0, "R9 withdraw");
    cyc(1,1,P1,0,1,1,1,1, 0,3'b000,0,0, "R9 late done");
    cyc(1,1,P1,0,1,1,1,0, 0,3'b000,0,0, "R9 quiet");

    // Beacon transmission
    for (int i = 0; i < 3; i++) cyc(1,1,P2,0,0,1,0,0, 0,3'b000,1,0, "R7 beacon in P2");
    cyc(1,1,P2,0,1,1,0,0, 0,3'b000,0,0, "R7 tx idle stops");
    cyc(1,1,P0,0,0,1,0,0, 0,3'b000,0,0, "R7 none in P0");
    cyc(1,1,P1,0,0,1,0,0, 0,3'b000,0,0, "R7 none in P1");

    // Beacon detection
    cyc(1,1,P2,0,1,1,0,0, 0,3'b000,0,0, "R8 idle line");
    cyc(1,1,P2,0,1,0,0,0, 0,3'b000,0,1, "R8 beacon seen");
    cyc(1,1,P2,0,1,0,0,0, 0,3'b000,0,0, "R8 pulse ends");
    cyc(1,1,P2,0,1,1,0,0, 0,3'b000,0,0, "R8 back to idle");
    cyc(1,1,P0,0,1,0,0,0, 0,3'b000,0,0, "R8 none in P0");
    cyc(1,1,P0,0,1,1,0,0, 0,3'b000,0,0, "R8 quiet");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
    rst_n = 0; pwr_state = P2; tx_idle = 0;
    #1;
    e.ps = 1; e.rs = 0; e.be = 0; e.bs = 0; e.tag = "R1 reset mid-run";
    compare(e);
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule